// File: doc/BRIEF.md
# Packed SIMD Floating-Point Multiplier

This block multiplies two packed vectors lane by lane in IEEE 754 binary floating point. A format control splits each operand into either 32-bit single-precision lanes or 64-bit double-precision lanes. A length control chooses between a half-width operation, which uses only the low 64 bits, and a full-width operation over all 128 bits. Every lane rounds its own product under a shared 2-bit rounding mode. It handles zeros, infinities, NaNs and subnormals, and it detects the four exceptions that a multiply can raise.

Operations enter through a valid/ready handshake and leave one cycle after acceptance from an output register that holds its value while the consumer stalls. The exceptions raised by the active lanes are merged. Each merged exception goes one of two ways, set by its enable bit. With the bit set, the exception requests a trap alongside the result. With the bit clear, it sets a sticky status flag that only a dedicated clear input resets. The pairing of double lanes with a half-width vector is reserved and is reported as illegal.

Top module: `simd_fmul`

## Requirements
- R1: With `lane_dbl`=0 the vectors hold four single-precision lanes at bit offsets 32*i. With `lane_dbl`=1 they hold two double-precision lanes at bit offsets 64*j. Result lane i is the product of lane i of `src_a` and lane i of `src_b`.
- R2: With `vec_full`=0 only the lanes inside bits 63:0 are computed. Bits 127:64 of the result are zero, and the upper lanes never raise an exception.
- R3: `lane_dbl`=1 together with `vec_full`=0 is illegal. It returns `out_illegal`=1 and an all-zero result, raises no trap and leaves `exc_flags` unchanged.
- R4: A finite nonzero product is rounded to the lane format. Under round-to-nearest-even, an exact tie goes to the even significand.
- R5: `rnd_mode` encodes 00 nearest-even, 01 toward +infinity, 10 toward -infinity and 11 toward zero.
- R6: Subnormal operands take part at full value, and results below the normal range are returned as correctly rounded subnormals or zero. Underflow is raised when the product is tiny before rounding and also inexact.
- R7: A rounded result beyond the largest finite value raises overflow and inexact. It returns infinity under nearest-even, under toward-zero it returns the largest finite value, and under the two directed modes it returns infinity only when that mode rounds away from zero.
- R8: Infinity times zero returns the default NaN (sign 0, exponent all ones, only the top fraction bit set) and raises invalid. A signalling NaN operand raises invalid and is returned with its top fraction bit set. When both operands are NaN, `src_a` is chosen. A quiet NaN operand raises nothing.
- R9: For every result that is not a NaN, including zeros and infinities, the sign is the XOR of the operand signs.
- R10: `exc_flags` bit 0 is invalid, bit 1 overflow, bit 2 underflow and bit 3 inexact. Exceptions from the active lanes are ORed into the flags when an operation is accepted. The flags stay set until `flag_clr`, and a clear in the same cycle as an acceptance drops only the older flags.
- R11: An exception whose `trap_en` bit (same bit order as R10) is set asserts `out_trap` together with that operation's result and does not set its flag. Exceptions whose enable bits are clear still set their flags.
- R12: `in_ready` is high when the output register is empty or is being read. The result appears in the cycle after acceptance and is held stable while `out_valid`=1 and `out_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| src_a | input | 128 | First packed operand |
| src_b | input | 128 | Second packed operand |
| lane_dbl | input | 1 | 0: single lanes, 1: double lanes |
| vec_full | input | 1 | 0: low 64 bits, 1: all 128 bits |
| rnd_mode | input | 2 | Rounding mode (R5) |
| trap_en | input | 4 | Per-exception trap enables (R10 order) |
| flag_clr | input | 1 | Clears the sticky flags |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Packed product |
| out_trap | output | 1 | Trap request for this result |
| out_illegal | output | 1 | Reserved configuration was used |
| exc_flags | output | 4 | Sticky exception flags |

## Verification
The bench goes after the rounding boundaries. These are an exact tie, where a design that rounds half up would return an odd significand, and a negative inexact product under the directed modes, where a design that ignores the sign would round the wrong way. It drives subnormal operands and results: a design that drops the hidden-bit handling or the denormalising shift would return a normal number or zero, and one that flags exact tiny results would report a spurious underflow. It checks overflow saturation per mode, quieting of signalling NaNs, the default NaN for infinity times zero, and signed zeros. It also checks that half-width lanes holding an invalid operand leave the flags clear, that the illegal configuration keeps earlier flags, and that an enabled exception traps without touching its flag while the exceptions that are not enabled still set theirs.

// File: rtl/simd_fmul_pkg.sv
package simd_fmul_pkg;
   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_POS_INF = 2'b01,
      RM_NEG_INF = 2'b10,
      RM_ZERO    = 2'b11
   } rnd_mode_e;

   localparam int EXC_NV = 0;
   localparam int EXC_OF = 1;
   localparam int EXC_UF = 2;
   localparam int EXC_NX = 3;
   localparam int EXC_W  = 4;

   localparam int SP_EXP  = 8;
   localparam int SP_FRAC = 23;
   localparam int DP_EXP  = 11;
   localparam int DP_FRAC = 52;
endpackage

// File: rtl/fpm_lane_mul.sv
module fpm_lane_mul
   import simd_fmul_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] op_a,
   input  logic [EXP_W+FRAC_W:0] op_b,
   input  logic [1:0]            rnd,
   output logic [EXP_W+FRAC_W:0] prod,
   output logic [EXC_W-1:0]      exc
);
   localparam int W    = 1 + EXP_W + FRAC_W;
   localparam int P    = FRAC_W + 1;
   localparam int PW   = 2 * P;
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int EMAX = (1 << EXP_W) - 1;
   localparam int SW   = EXP_W + 3;
   localparam int LZW  = $clog2(PW) + 1;

   if (EXP_W < 4 || FRAC_W < 4) begin : g_bad_fmt
      $error("fpm_lane_mul: format too narrow");
   end

   function automatic logic [LZW-1:0] lead_zeros(input logic [PW-1:0] v);
      lead_zeros = LZW'(PW);
      for (int i = 0; i < PW; i++)
         if (v[i]) lead_zeros = LZW'(PW - 1 - i);
   endfunction

   logic             sgn;
   logic [EXP_W-1:0] ea, eb;
   logic [FRAC_W-1:0] fa, fb;
   logic             a_zero, b_zero, a_inf, b_inf, a_nan, b_nan, a_snan, b_snan;
   logic [P-1:0]     sig_a, sig_b;
   logic [SW-1:0]    ex_a, ex_b, e_norm, rsh_raw, exp_r;
   logic [PW-1:0]    raw, norm, mant;
   logic [2*PW-1:0]  wide;
   logic [LZW-1:0]   lz;
   logic [SW-1:0]    shamt;
   logic             tiny, grd, stk, inc, ovf, to_inf, inexact;
   logic [P:0]       rsum;

   assign ea = op_a[W-2:FRAC_W];
   assign eb = op_b[W-2:FRAC_W];
   assign fa = op_a[FRAC_W-1:0];
   assign fb = op_b[FRAC_W-1:0];
   assign sgn = op_a[W-1] ^ op_b[W-1];

   assign a_zero = (ea == '0) && (fa == '0);
   assign b_zero = (eb == '0) && (fb == '0);
   assign a_inf  = (ea == '1) && (fa == '0);
   assign b_inf  = (eb == '1) && (fb == '0);
   assign a_nan  = (ea == '1) && (fa != '0);
   assign b_nan  = (eb == '1) && (fb != '0);
   assign a_snan = a_nan && !fa[FRAC_W-1];
   assign b_snan = b_nan && !fb[FRAC_W-1];

   assign sig_a = {ea != '0, fa};
   assign sig_b = {eb != '0, fb};
   assign ex_a  = (ea == '0) ? SW'(1) : SW'(ea);
   assign ex_b  = (eb == '0) ? SW'(1) : SW'(eb);

   // significand product, normalised so its leading one sits in the top bit
   assign raw    = sig_a * sig_b;
   assign lz     = lead_zeros(raw);
   assign norm   = raw << lz;
   assign e_norm = ex_a + ex_b + SW'(1) - SW'(BIAS) - SW'(lz);
   assign tiny   = e_norm[SW-1] || (e_norm == '0);

   // tiny results are shifted right into the subnormal range
   assign rsh_raw = SW'(1) - e_norm;
   assign shamt   = !tiny ? '0 : ((rsh_raw > SW'(PW)) ? SW'(PW) : rsh_raw);
   assign wide    = {norm, {PW{1'b0}}} >> shamt;
   assign mant    = wide[2*PW-1:PW];
   assign grd     = mant[P-1];
   assign stk     = (|mant[P-2:0]) || (|wide[PW-1:0]);
   assign inexact = grd || stk;

   always_comb begin
      unique case (rnd_mode_e'(rnd))
         RM_NEAREST: inc = grd && (stk || mant[P]);
         RM_POS_INF: inc = !sgn && inexact;
         RM_NEG_INF: inc = sgn && inexact;
         default:    inc = 1'b0;
      endcase
      unique case (rnd_mode_e'(rnd))
         RM_NEAREST: to_inf = 1'b1;
         RM_POS_INF: to_inf = !sgn;
         RM_NEG_INF: to_inf = sgn;
         default:    to_inf = 1'b0;
      endcase
   end

   assign rsum  = {1'b0, mant[PW-1:P]} + (P+1)'(inc);
   assign exp_r = tiny ? SW'(rsum[P-1]) : e_norm + SW'(rsum[P]);
   assign ovf   = !tiny && (exp_r >= SW'(EMAX));

   always_comb begin
      exc = '0;
      if (a_nan || b_nan) begin
         prod = a_nan ? {op_a[W-1:FRAC_W], 1'b1, fa[FRAC_W-2:0]}
                      : {op_b[W-1:FRAC_W], 1'b1, fb[FRAC_W-2:0]};
         exc[EXC_NV] = a_snan || b_snan;
      end else if ((a_inf && b_zero) || (b_inf && a_zero)) begin
         prod = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
         exc[EXC_NV] = 1'b1;
      end else if (a_inf || b_inf) begin
         prod = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (a_zero || b_zero) begin
         prod = {sgn, {(W-1){1'b0}}};
      end else if (ovf) begin
         prod = to_inf ? {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                       : {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
         exc[EXC_OF] = 1'b1;
         exc[EXC_NX] = 1'b1;
      end else begin
         prod = {sgn, exp_r[EXP_W-1:0], rsum[FRAC_W-1:0]};
         exc[EXC_NX] = inexact;
         exc[EXC_UF] = tiny && inexact;
      end
   end
endmodule

// File: rtl/fpm_lane_array.sv
module fpm_lane_array
   import simd_fmul_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic             lane_dbl,
   input  logic             vec_full,
   input  logic [1:0]       rnd,
   output logic [VEC_W-1:0] res,
   output logic [EXC_W-1:0] exc
);
   localparam int SPW = 1 + SP_EXP + SP_FRAC;
   localparam int DPW = 1 + DP_EXP + DP_FRAC;
   localparam int NS  = VEC_W / SPW;
   localparam int ND  = VEC_W / DPW;

   logic [VEC_W-1:0]   res_s, res_d;
   logic [EXC_W-1:0]   exc_s [NS];
   logic [EXC_W-1:0]   exc_d [ND];

   for (genvar i = 0; i < NS; i++) begin : g_sp
      localparam bit LOW_HALF = (i < NS / 2);
      logic [SPW-1:0]   y;
      logic [EXC_W-1:0] e;
      logic             act;
      fpm_lane_mul #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_mul (
         .op_a (src_a[i*SPW +: SPW]),
         .op_b (src_b[i*SPW +: SPW]),
         .rnd  (rnd),
         .prod (y),
         .exc  (e)
      );
      assign act = vec_full || LOW_HALF;
      assign res_s[i*SPW +: SPW] = act ? y : '0;
      assign exc_s[i] = act ? e : '0;
   end

   for (genvar j = 0; j < ND; j++) begin : g_dp
      localparam bit LOW_HALF = (j < ND / 2);
      logic [DPW-1:0]   y;
      logic [EXC_W-1:0] e;
      logic             act;
      fpm_lane_mul #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_mul (
         .op_a (src_a[j*DPW +: DPW]),
         .op_b (src_b[j*DPW +: DPW]),
         .rnd  (rnd),
         .prod (y),
         .exc  (e)
      );
      assign act = vec_full || LOW_HALF;
      assign res_d[j*DPW +: DPW] = act ? y : '0;
      assign exc_d[j] = act ? e : '0;
   end

   always_comb begin
      logic [EXC_W-1:0] os, od;
      os = '0;
      od = '0;
      for (int i = 0; i < NS; i++) os |= exc_s[i];
      for (int j = 0; j < ND; j++) od |= exc_d[j];
      res = lane_dbl ? res_d : res_s;
      exc = lane_dbl ? od : os;
   end
endmodule

// File: rtl/simd_fmul.sv
module simd_fmul
   import simd_fmul_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic             lane_dbl,
   input  logic             vec_full,
   input  logic [1:0]       rnd_mode,
   input  logic [3:0]       trap_en,
   input  logic             flag_clr,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [VEC_W-1:0] out_result,
   output logic             out_trap,
   output logic             out_illegal,
   output logic [3:0]       exc_flags
);
   localparam int HALF = VEC_W / 2;

   if (VEC_W < 128 || (VEC_W % 128) != 0) begin : g_bad_width
      $error("simd_fmul: VEC_W must be a multiple of 128");
   end

   logic [VEC_W-1:0] lane_res;
   logic [EXC_W-1:0] lane_exc, raised;
   logic             illegal_cfg, accept;

   fpm_lane_array #(.VEC_W(VEC_W)) u_lanes (
      .src_a    (src_a),
      .src_b    (src_b),
      .lane_dbl (lane_dbl),
      .vec_full (vec_full),
      .rnd      (rnd_mode),
      .res      (lane_res),
      .exc      (lane_exc)
   );

   assign illegal_cfg = lane_dbl && !vec_full;
   assign raised      = illegal_cfg ? '0 : lane_exc;
   assign in_ready    = !out_valid || out_ready;
   assign accept      = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_trap    <= 1'b0;
         out_illegal <= 1'b0;
         exc_flags   <= '0;
      end else begin
         if (accept) begin
            out_valid   <= 1'b1;
            out_result  <= illegal_cfg ? '0 : lane_res;
            out_trap    <= |(raised & trap_en);
            out_illegal <= illegal_cfg;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
         exc_flags <= (flag_clr ? '0 : exc_flags) | (accept ? (raised & ~trap_en) : '0);
      end
   end

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !vec_full |=> out_result[VEC_W-1:HALF] == '0); // R2
   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      accept && lane_dbl && !vec_full && !flag_clr |=>
         out_illegal && !out_trap && exc_flags == $past(exc_flags)); // R3
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_clr |=> (exc_flags & $past(exc_flags)) == $past(exc_flags)); // R10
   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && !accept |=> exc_flags == '0); // R10
   AST_TRAP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !flag_clr |=> ((exc_flags & ~$past(exc_flags)) & $past(trap_en)) == '0); // R11
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_result)); // R12
endmodule

// File: tb/simd_fmul_tb.sv
module simd_fmul_tb;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0, in_ready;
   logic [127:0] src_a = '0, src_b = '0;
   logic         lane_dbl = 1'b0, vec_full = 1'b1;
   logic [1:0]   rnd_mode = 2'b00;
   logic [3:0]   trap_en = '0;
   logic         flag_clr = 1'b0;
   logic         out_valid, out_ready = 1'b1;
   logic [127:0] out_result;
   logic         out_trap, out_illegal;
   logic [3:0]   exc_flags;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [127:0] res;
      logic         trap;
      logic         ill;
      string        tag;
   } exp_t;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_fmul u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .src_a(src_a), .src_b(src_b), .lane_dbl(lane_dbl), .vec_full(vec_full),
      .rnd_mode(rnd_mode), .trap_en(trap_en), .flag_clr(flag_clr),
      .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
      .out_trap(out_trap), .out_illegal(out_illegal), .exc_flags(exc_flags)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // monitor: pops the scoreboard as results leave the design
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R12 unexpected result", out_result, '0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(out_result == e.res, {e.tag, " result"}, out_result, e.res);
            chk({out_trap, out_illegal} == {e.trap, e.ill}, {e.tag, " trap/illegal"},
                128'({out_trap, out_illegal}), 128'({e.trap, e.ill}));
         end
      end
   end

   task automatic issue(input logic [127:0] a, b, input logic dbl, full, input logic [1:0] rm,
                        input logic [3:0] en, input logic clr, input logic [127:0] er,
                        input logic etrap, eill, input string tag);
      exp_t e;
      bit rdy;
      e.res = er; e.trap = etrap; e.ill = eill; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk);
      src_a = a; src_b = b; lane_dbl = dbl; vec_full = full; rnd_mode = rm;
      trap_en = en; flag_clr = clr; in_valid = 1'b1;
      forever begin
         rdy = in_ready;
         @(posedge clk);
         if (rdy) break;
         @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      flag_clr = 1'b0;
   endtask

   task automatic drain;
      #1;
      while (sb_q.size() != 0) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic run(input logic [127:0] a, b, input logic dbl, full, input logic [1:0] rm,
                      input logic [3:0] en, input logic clr, input logic [127:0] er,
                      input logic etrap, eill, input logic [3:0] eflags, input string tag);
      issue(a, b, dbl, full, rm, en, clr, er, etrap, eill, tag);
      drain();
      chk(exc_flags == eflags, {tag, " flags"}, 128'(exc_flags), 128'(eflags));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [127:0] dA, dB, dE;
      dA = {$realtobits(1.0/3.0), $realtobits(1.25)};
      dB = {$realtobits(1.0/7.0), $realtobits(3.0)};
      dE = {$realtobits((1.0/3.0)*(1.0/7.0)), $realtobits(1.25*3.0)};

      repeat (3) @(negedge clk);
      chk(!out_valid && in_ready && exc_flags == 4'h0, "R12 reset state",
          128'({out_valid, in_ready, exc_flags}), 128'({1'b0, 1'b1, 4'h0}));
      rst_n = 1'b1;

      // R1 single lanes, exact products
      run({32'hC0000000, 32'h40400000, 32'hBF800000, 32'h3FC00000},
          {32'hC0000000, 32'h40800000, 32'h3F000000, 32'h40000000}, 0, 1, 2'b00, 4'h0, 1,
          {32'h40800000, 32'h41400000, 32'hBF000000, 32'h40400000}, 0, 0, 4'h0, "R1 single");
      // R1 double lanes, host double arithmetic as reference
      run(dA, dB, 1, 1, 2'b00, 4'h0, 1, dE, 0, 0, 4'h8, "R1 double");
      // R3 illegal keeps the inexact flag from the previous operation
      run({4{32'h7F800000}}, {4{32'h00000000}}, 1, 0, 2'b00, 4'hF, 0, '0, 0, 1, 4'h8, "R3 illegal");
      // R2 half width: upper lanes hold inf*0 but must stay silent
      run({32'h7F800000, 32'h7F800000, 32'h3FC00000, 32'h40400000},
          {32'h00000000, 32'h00000000, 32'h40000000, 32'h40800000}, 0, 0, 2'b00, 4'h0, 1,
          {64'h0, 32'h40400000, 32'h41400000}, 0, 0, 4'h0, "R2 half");
      // R4 tie to even, R5 toward zero on the same operands
      run({4{32'h3FC00000}}, {4{32'h3F800001}}, 0, 1, 2'b00, 4'h0, 1,
          {4{32'h3FC00002}}, 0, 0, 4'h8, "R4 tie even");
      run({4{32'h3FC00000}}, {4{32'h3F800001}}, 0, 1, 2'b11, 4'h0, 1,
          {4{32'h3FC00001}}, 0, 0, 4'h8, "R5 toward zero");
      // R5 directed modes with mixed signs
      run({32'hBF800001, 32'hBF800001, 32'h3F800001, 32'h3F800001}, {4{32'h3F800001}}, 0, 1, 2'b01,
          4'h0, 1, {32'hBF800002, 32'hBF800002, 32'h3F800003, 32'h3F800003}, 0, 0, 4'h8, "R5 up");
      run({32'hBF800001, 32'hBF800001, 32'h3F800001, 32'h3F800001}, {4{32'h3F800001}}, 0, 1, 2'b10,
          4'h0, 1, {32'hBF800003, 32'hBF800003, 32'h3F800002, 32'h3F800002}, 0, 0, 4'h8, "R5 down");
      // R6 subnormal inputs and outputs
      run({32'h0D800000, 32'h00000001, 32'h00000003, 32'h00800000},
          {32'h30800000, 32'h71800000, 32'h3F000000, 32'h3F000000}, 0, 1, 2'b00, 4'h0, 1,
          {32'h00080000, 32'h27000000, 32'h00000002, 32'h00400000}, 0, 0, 4'hC, "R6 subnormal");
      run({32'h0D800000, 32'h00000001, 32'h00000001, 32'h00800000},
          {32'h30800000, 32'h71800000, 32'h40000000, 32'h3F000000}, 0, 1, 2'b11, 4'h0, 1,
          {32'h00080000, 32'h27000000, 32'h00000002, 32'h00400000}, 0, 0, 4'h0, "R6 exact tiny");
      // R7 overflow per mode
      run({4{32'h71800000}}, {4{32'h71800000}}, 0, 1, 2'b00, 4'h0, 1,
          {4{32'h7F800000}}, 0, 0, 4'hA, "R7 nearest");
      run({4{32'h71800000}}, {4{32'h71800000}}, 0, 1, 2'b11, 4'h0, 1,
          {4{32'h7F7FFFFF}}, 0, 0, 4'hA, "R7 toward zero");
      run({32'hF1800000, 32'hF1800000, 32'h71800000, 32'h71800000}, {4{32'h71800000}}, 0, 1, 2'b01,
          4'h0, 1, {32'hFF7FFFFF, 32'hFF7FFFFF, 32'h7F800000, 32'h7F800000}, 0, 0, 4'hA, "R7 up");
      // R8 NaN handling
      run({32'h7F800001, 32'h7F800000, 32'h3F800000, 32'hFF800000},
          {32'h3F800000, 32'h00000000, 32'hFFC00005, 32'h80000000}, 0, 1, 2'b00, 4'h0, 1,
          {32'h7FC00001, 32'h7FC00000, 32'hFFC00005, 32'h7FC00000}, 0, 0, 4'h1, "R8 nan");
      run({4{32'h7FC00002}}, {4{32'h7F800001}}, 0, 1, 2'b00, 4'h0, 1,
          {4{32'h7FC00002}}, 0, 0, 4'h1, "R8 both nan");
      // R9 sign of zeros and infinities
      run({32'hFF800000, 32'h80000000, 32'h80000000, 32'hBF800000},
          {32'h40000000, 32'h40400000, 32'h80000000, 32'hBF800000}, 0, 1, 2'b00, 4'h0, 1,
          {32'hFF800000, 32'h80000000, 32'h00000000, 32'h3F800000}, 0, 0, 4'h0, "R9 sign");
      // R10 sticky accumulation and clear
      run({4{32'h7F800000}}, {4{32'h00000000}}, 0, 1, 2'b00, 4'h0, 1,
          {4{32'h7FC00000}}, 0, 0, 4'h1, "R10 first");
      run({4{32'h71800000}}, {4{32'h71800000}}, 0, 1, 2'b00, 4'h0, 0,
          {4{32'h7F800000}}, 0, 0, 4'hB, "R10 accumulate");
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      chk(exc_flags == 4'h0, "R10 clear", 128'(exc_flags), 128'h0);
      // R11 traps
      run({4{32'h7F800000}}, {4{32'h00000000}}, 0, 1, 2'b00, 4'h1, 1,
          {4{32'h7FC00000}}, 1, 0, 4'h0, "R11 invalid trap");
      run({4{32'h3FC00000}}, {4{32'h3F800001}}, 0, 1, 2'b00, 4'h8, 1,
          {4{32'h3FC00002}}, 1, 0, 4'h0, "R11 inexact trap");
      run({4{32'h71800000}}, {4{32'h71800000}}, 0, 1, 2'b00, 4'h2, 1,
          {4{32'h7F800000}}, 1, 0, 4'h8, "R11 overflow trap");
      // R12 stall holds the result
      @(negedge clk); out_ready = 1'b0;
      issue({4{32'h40000000}}, {4{32'h40400000}}, 0, 1, 2'b00, 4'h0, 1,
            {4{32'h40C00000}}, 0, 0, "R12 stalled");
      repeat (3) @(negedge clk);
      chk(out_valid && !in_ready && out_result == {4{32'h40C00000}}, "R12 hold",
          out_result, {4{32'h40C00000}});
      out_ready = 1'b1;
      drain();
      summary();
      $finish;
   end
endmodule